// File: doc/BRIEF.md
# Serial Idle-Line Detector

This block sits behind the bit sampler of an asynchronous serial receiver and watches the receive line one bit-time at a time. A line counts as idle when it has been at logic one for a whole frame. The frame is 10 bit-times with the 8-bit data setting and 11 bit-times with the 9-bit data setting. When the block finds such a run, it sets a sticky idle flag. If the interrupt enable is on, the flag also raises an interrupt request.

There are two detection modes, and detection is always running. Short mode counts every consecutive one, including the stop bit and any ones before it, so it gives the earliest possible recognition. Long mode starts counting only after a stop bit has been received, so only a complete idle frame can set the flag. Once the flag has been set, a further flag is held back until a new frame has been received. A long idle stretch therefore produces a single event. The receive status logic pulses the clear input when software reads status and then data.

Top module: `idle_det`

## Requirements
- R1: After reset, `idleFlag` and `idleIrq` are 0 and the detector is armed: the first qualifying idle run sets the flag with no `frameDone` needed.
- R2: The idle run length is 10 bit-times when `nineBit` is 0 and 11 when `nineBit` is 1. The flag is set at the clock edge of the bit-time that completes the run, never one bit-time early.
- R3: A sampled zero (`bitStrobe`=1, `bitValue`=0) restarts the count of ones from zero.
- R4: With `modeLong`=0, every sampled one counts toward the run, including the bit-time flagged by `stopSeen`.
- R5: With `modeLong`=1, ones count only after a bit-time with `stopSeen`=1. That stop bit-time is not counted, and ones that follow a zero without a stop bit in between never set the flag.
- R6: Once the flag is set, it stays at 1 until a `flagClear` pulse. If the flag is being set in the same cycle as a clear, the set wins.
- R7: After the flag has been set, it cannot be set again until `frameDone` has pulsed. A continuing idle run after a clear therefore gives no second flag.
- R8: `idleIrq` is 1 exactly when `idleFlag` is 1 and `idleIntEn` is 1.
- R9: In cycles with `bitStrobe`=0, `bitValue` and `stopSeen` are ignored, and the run count is neither advanced nor cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitStrobe | input | 1 | One-cycle pulse per received bit-time |
| bitValue | input | 1 | Sampled line value for this bit-time |
| stopSeen | input | 1 | With `bitStrobe`, marks this bit-time as a received stop bit |
| frameDone | input | 1 | Pulse when a complete frame has been received |
| modeLong | input | 1 | 0 selects short detection, 1 selects long detection |
| nineBit | input | 1 | 0 selects an 8-bit data frame (10 bit-times), 1 selects 9-bit (11) |
| idleIntEn | input | 1 | Interrupt enable for the idle flag |
| flagClear | input | 1 | Pulse that clears the idle flag |
| idleFlag | output | 1 | Sticky idle-line flag |
| idleIrq | output | 1 | Interrupt request |

## Verification
The detector is driven with runs of ones that stop one bit-time short of a frame and runs that complete it, in both frame lengths. This separates an off-by-one in the length select from a correct count. In long mode, ones placed before the stop bit are pushed past the frame length so that they would fire wrongly if they were counted; short mode sees the same pattern and must fire. Clear pulses are placed during a continuing idle run, before and after `frameDone`, and in the same cycle as a completing bit, which separates the re-arm and priority rules from a plain set/clear latch. A long seeded random stream of biased bits, stop marks, frame pulses and mode changes is then compared each cycle against a model in the bench.

// File: rtl/idle_det_pkg.sv
package idle_det_pkg;

  // strobes from the control to the run counter
  typedef struct packed {
    logic cntInc;   // a counted one arrived this bit-time
    logic cntClr;   // restart the run from zero
  } dpCmd_t;

endpackage

// File: rtl/idle_det_dp.sv
module idle_det_dp
  import idle_det_pkg::*;
#(
  parameter int SHORT_FRAME = 10,
  parameter int LONG_FRAME  = 11,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCmd_t           cmd,
  input  logic             nineBit,
  output logic [CNT_W-1:0] runCount,
  output logic             fillHit
);

  localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_FRAME);
  localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(LONG_FRAME);

  logic [CNT_W-1:0] frameLen;
  logic [CNT_W-1:0] cntQ;

  assign frameLen = nineBit ? LONG_LEN : SHORT_LEN;

  // saturating run counter; holds once the frame length is reached
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (cmd.cntClr) begin
      cntQ <= '0;
    end else if (cmd.cntInc && (cntQ < frameLen)) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // this counted one completes a full frame of ones
  assign fillHit  = cmd.cntInc && (cntQ == frameLen - 1'b1);
  assign runCount = cntQ;

endmodule

// File: rtl/idle_det_ctl.sv
module idle_det_ctl
  import idle_det_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bitStrobe,
  input  logic   bitValue,
  input  logic   stopSeen,
  input  logic   frameDone,
  input  logic   modeLong,
  input  logic   flagClear,
  input  logic   fillHit,
  output dpCmd_t cmd,
  output logic   idleFlag,
  output logic   rearmed
);

  logic longArmed;
  logic flagQ;
  logic rearmQ;
  logic setFlag;
  logic gateLong;

  // long mode: no counting before a stop bit, and not the stop bit itself
  assign gateLong = modeLong && (stopSeen || !longArmed);

  always_comb begin
    cmd        = '0;
    cmd.cntClr = bitStrobe && (!bitValue || (modeLong && stopSeen));
    cmd.cntInc = bitStrobe && bitValue && !gateLong;
  end

  assign setFlag = fillHit && rearmQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      longArmed <= 1'b0;
    end else if (bitStrobe) begin
      if (!bitValue) begin
        longArmed <= 1'b0;
      end else if (stopSeen) begin
        longArmed <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rearmQ <= 1'b1;
    end else if (setFlag) begin
      rearmQ <= 1'b0;
    end else if (frameDone) begin
      rearmQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagQ <= 1'b0;
    end else if (setFlag) begin
      flagQ <= 1'b1;
    end else if (flagClear) begin
      flagQ <= 1'b0;
    end
  end

  assign idleFlag = flagQ;
  assign rearmed  = rearmQ;

endmodule

// File: rtl/idle_det.sv
module idle_det
  import idle_det_pkg::*;
#(
  parameter int SHORT_DATA_BITS = 8,
  parameter int LONG_DATA_BITS  = 9,
  parameter int FRAME_OVERHEAD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bitStrobe,
  input  logic bitValue,
  input  logic stopSeen,
  input  logic frameDone,
  input  logic modeLong,
  input  logic nineBit,
  input  logic idleIntEn,
  input  logic flagClear,
  output logic idleFlag,
  output logic idleIrq
);

  localparam int SHORT_FRAME = SHORT_DATA_BITS + FRAME_OVERHEAD;
  localparam int LONG_FRAME  = LONG_DATA_BITS + FRAME_OVERHEAD;
  localparam int MAX_FRAME   = (LONG_FRAME > SHORT_FRAME) ? LONG_FRAME : SHORT_FRAME;
  localparam int CNT_W       = $clog2(MAX_FRAME + 1);

  dpCmd_t           cmd;
  logic             fillHit;
  logic [CNT_W-1:0] runCount;
  logic             rearmed;

  idle_det_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bitStrobe (bitStrobe),
    .bitValue  (bitValue),
    .stopSeen  (stopSeen),
    .frameDone (frameDone),
    .modeLong  (modeLong),
    .flagClear (flagClear),
    .fillHit   (fillHit),
    .cmd       (cmd),
    .idleFlag  (idleFlag),
    .rearmed   (rearmed)
  );

  idle_det_dp #(
    .SHORT_FRAME (SHORT_FRAME),
    .LONG_FRAME  (LONG_FRAME),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .nineBit  (nineBit),
    .runCount (runCount),
    .fillHit  (fillHit)
  );

  assign idleIrq = idleFlag && idleIntEn;

endmodule

// File: rtl/idle_det_chk.sv
module idle_det_chk #(
  parameter int MAX_FRAME = 11,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bitStrobe,
  input logic             bitValue,
  input logic             frameDone,
  input logic             flagClear,
  input logic             idleIntEn,
  input logic             idleFlag,
  input logic             idleIrq,
  input logic [CNT_W-1:0] runCount,
  input logic             rearmed
);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idleIrq |-> idleFlag);

  // R8
  irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idleFlag && idleIntEn) |-> idleIrq);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idleFlag && !flagClear) |=> idleFlag);

  // R7
  rearm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rearmed && !frameDone) |=> !$rose(idleFlag));

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bitStrobe |=> $stable(runCount));

  // R3
  zero_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitStrobe && !bitValue) |=> (runCount == '0));

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runCount <= CNT_W'(MAX_FRAME));

  // R2
  set_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idleFlag) |-> $past(bitStrobe && bitValue));

endmodule

bind idle_det idle_det_chk #(
  .MAX_FRAME (MAX_FRAME),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bitStrobe (bitStrobe),
  .bitValue  (bitValue),
  .frameDone (frameDone),
  .flagClear (flagClear),
  .idleIntEn (idleIntEn),
  .idleFlag  (idleFlag),
  .idleIrq   (idleIrq),
  .runCount  (runCount),
  .rearmed   (rearmed)
);

// File: tb/idle_det_tb.sv
`timescale 1ns/1ps
module idle_det_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitStrobe = 1'b0, bitValue = 1'b1, stopSeen = 1'b0, frameDone = 1'b0;
  logic modeLong = 1'b0, nineBit = 1'b0, idleIntEn = 1'b1, flagClear = 1'b0;
  logic idleFlag, idleIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // bench model state
  int mCnt = 0;
  bit mArmed = 1'b0;
  bit mRearm = 1'b1;
  bit mFlag = 1'b0;

  always #10 clk = ~clk;

  idle_det u_dut (
    .clk(clk), .rst_n(rst_n), .bitStrobe(bitStrobe), .bitValue(bitValue),
    .stopSeen(stopSeen), .frameDone(frameDone), .modeLong(modeLong),
    .nineBit(nineBit), .idleIntEn(idleIntEn), .flagClear(flagClear),
    .idleFlag(idleFlag), .idleIrq(idleIrq)
  );

  function automatic int frameOf(bit nine);
    return nine ? 11 : 10;   // R2
  endfunction

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // model one clock of the requirements, given the current inputs
  task automatic modelStep();
    bit hit = 1'b0;
    int len = frameOf(nineBit);
    if (bitStrobe) begin
      if (!bitValue) begin
        mCnt = 0; mArmed = 1'b0;                 // R3
      end else if (modeLong && stopSeen) begin
        mCnt = 0; mArmed = 1'b1;                 // R5
      end else begin
        if (stopSeen) mArmed = 1'b1;
        if (!modeLong || mArmed) begin           // R4 / R5
          if (mCnt < len) begin
            if (mCnt + 1 == len) hit = 1'b1;
            mCnt = mCnt + 1;
          end
        end
      end
    end
    if (hit && mRearm) begin
      mFlag = 1'b1; mRearm = 1'b0;               // R6 set wins, R7
    end else begin
      if (frameDone) mRearm = 1'b1;
      if (flagClear) mFlag = 1'b0;
    end
  endtask

  // called at a negedge: apply inputs, advance, compare at next negedge
  task automatic step(string tag, bit s, bit v, bit st, bit fd, bit cl);
    bitStrobe = s; bitValue = v; stopSeen = st; frameDone = fd; flagClear = cl;
    modelStep();
    @(negedge clk);
    check({tag, " flag"}, idleFlag, mFlag);
    check({tag, " irq (R8)"}, idleIrq, mFlag & idleIntEn);
  endtask

  task automatic ones(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1, 1, 0, 0, 0);
  endtask

  task automatic zeroBit(string tag);
    step(tag, 1, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset flag", idleFlag, 1'b0);
    check("R1 reset irq", idleIrq, 1'b0);
    rst_n = 1'b1;

    // R1 / R4 / R2: short mode, 8-bit; run of 9 ones then the 10th
    zeroBit("R3 start");
    ones("R2 nine ones short of frame", 9);
    check("R2 no early flag", idleFlag, 1'b0);
    ones("R4 tenth one", 1);
    check("R1 armed from reset, R4 flag set", idleFlag, 1'b1);

    // R6 / R7: clear during continuing idle, no re-flag until frameDone
    step("R6 clear", 0, 0, 0, 0, 1);
    check("R6 cleared", idleFlag, 1'b0);
    zeroBit("R7 zero");
    ones("R7 full run not rearmed", 12);
    check("R7 held off", idleFlag, 1'b0);
    step("R7 frame received", 0, 0, 0, 1, 0);
    zeroBit("R7 zero");
    ones("R7 run after rearm", 10);
    check("R7 flag after rearm", idleFlag, 1'b1);

    // R6: set and clear in the same cycle -> set wins
    step("R6 clear", 0, 0, 0, 1, 1);
    zeroBit("R6 zero");
    ones("R6 run", 9);
    step("R6 set beats clear", 1, 1, 0, 0, 1);
    check("R6 set priority", idleFlag, 1'b1);

    // R3: zero mid-run restarts count
    step("R3 clear+rearm", 0, 0, 0, 1, 1);
    ones("R3 ones", 5);
    zeroBit("R3 mid zero");
    ones("R3 nine after zero", 9);
    check("R3 restart", idleFlag, 1'b0);
    ones("R3 tenth after zero", 1);
    check("R3 flag", idleFlag, 1'b1);

    // R2: nine-bit frame = 11
    step("R2 clear+rearm", 0, 0, 0, 1, 1);
    nineBit = 1'b1;
    zeroBit("R2 zero");
    ones("R2 ten ones", 10);
    check("R2 no flag at 10 of 11", idleFlag, 1'b0);
    ones("R2 eleventh", 1);
    check("R2 flag at 11", idleFlag, 1'b1);
    nineBit = 1'b0;

    // R5: long mode ignores ones before the stop bit, and the stop bit
    step("R5 clear+rearm", 0, 0, 0, 1, 1);
    modeLong = 1'b1;
    zeroBit("R5 zero");
    ones("R5 ones without stop", 12);
    check("R5 no flag before stop", idleFlag, 1'b0);
    step("R5 stop bit", 1, 1, 1, 1, 0);
    ones("R5 nine after stop", 9);
    check("R5 not yet", idleFlag, 1'b0);
    ones("R5 tenth after stop", 1);
    check("R5 full idle frame", idleFlag, 1'b1);

    // R4: short mode counts the stop bit itself
    step("R4 clear+rearm", 0, 0, 0, 1, 1);
    modeLong = 1'b0;
    zeroBit("R4 zero");
    ones("R4 ones", 4);
    step("R4 stop counted", 1, 1, 1, 0, 0);
    ones("R4 rest", 5);
    check("R4 flag incl stop", idleFlag, 1'b1);

    // R9: non-strobe cycles with a zero on the line are ignored
    step("R9 clear+rearm", 0, 0, 0, 1, 1);
    zeroBit("R9 zero");
    ones("R9 ones", 6);
    for (int i = 0; i < 4; i++) step("R9 ignored zero", 0, 0, 1, 0, 0);
    ones("R9 ones", 4);
    check("R9 run kept", idleFlag, 1'b1);

    // R8: irq follows enable
    idleIntEn = 1'b0;
    @(negedge clk);
    check("R8 irq masked", idleIrq, 1'b0);
    idleIntEn = 1'b1;
    @(negedge clk);
    check("R8 irq raised", idleIrq, 1'b1);

    // random stream
    for (int n = 0; n < 6000; n++) begin
      bit s  = ($urandom % 2) == 0;
      bit v  = ($urandom % 16) != 0;
      bit st = s && v && (($urandom % 12) == 0);
      bit fd = ($urandom % 40) == 0;
      bit cl = ($urandom % 20) == 0;
      if (($urandom % 300) == 0) modeLong = ~modeLong;
      if (($urandom % 300) == 0) nineBit = ~nineBit;
      if (($urandom % 50) == 0) idleIntEn = ~idleIntEn;
      step(modeLong ? "R5 random" : "R4 random", s, v, st, fd, cl);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule